// File: doc/BRIEF.md
# Prioritized Interrupt Offset Register

This block holds three groups of sticky per-channel event flags (buffer full, request lost, bus error) for a set of channel pairs, and presents one read-only status word that names the single most urgent pending event routed to this interrupt line. A per-channel line-map vector decides which channels take part in the selection for this line. Flags that are masked off stay stored and reappear in the selection as soon as their map bit is set again.

The status word carries a two-bit event type and a channel offset. Reading the word with an access that covers both the type and the offset clears the flag that produced the reported event. The word then moves on to the next pending event one clock later, with no further software action. While the debug input is high, reads return the same value but leave every flag untouched. A byte-wide read never clears anything, because it cannot return type and offset together. The read data port presents the current word continuously. The interrupt request output is high whenever an event is reported.

Top module: `irq_offset_reg`

## Requirements
- R1: After reset, all flags are clear, the read word is 0 and irq_line is low.
- R2: A channel takes part in the selection only while its line_map bit is 1. Flags of masked channels are not reported.
- R3: Bits 9:8 of the read word give the event type: 0 none, 1 buffer full, 2 request lost, 3 bus error. Bus error has the highest priority, then request lost, then buffer full.
- R4: Bits 3:0 give the channel of the reported event, numbered 2×pair + sub-channel (sub-channel A = 0, B = 1). Within the winning type, the lowest numbered channel is reported.
- R5: Bits 31:10 and 7:4 of the read word are always 0.
- R6: A read with rd_be[0] and rd_be[1] both high, with debug_mode low and a nonzero type, clears the reported flag at the next clock edge. The word shows the next pending event in the following cycle.
- R7: A read while debug_mode is high changes no flag.
- R8: A read with rd_be[0] or rd_be[1] low (a byte access) changes no flag.
- R9: A set pulse raises its flag at the next clock edge. If a set pulse and a read-clear target the same flag in the same cycle, the flag stays set.
- R10: irq_line is high exactly when the type field is nonzero.
- R11: Flags are sticky. They stay set across line_map changes until a qualifying read clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_bfull | input | 16 | Buffer-full set pulses, one per channel |
| set_rlost | input | 16 | Request-lost set pulses, one per channel |
| set_berr | input | 16 | Bus-error set pulses, one per channel |
| line_map | input | 16 | Per-channel routing to this interrupt line (1 = routed) |
| debug_mode | input | 1 | Suppresses clear-on-read while high |
| rd_en | input | 1 | Register read strobe |
| rd_be | input | 4 | Byte enables of the read access |
| rd_data | output | 32 | Status word: type in 9:8, channel in 3:0 |
| irq_line | output | 1 | Interrupt request for this line |

## Verification
A flag bank that drops or keeps a bit wrongly shows in the status word no later than the cycle after the read or set pulse that caused it. The word either repeats an event that should be gone or skips ahead to a lower-priority one. A wrong priority or mask decision shows in the same cycle the inputs are applied, because the word is computed from the stored flags and the current map. Each cycle the bench compares the word and the interrupt line against a model of the flag groups. The bench mixes random sparse set pulses, map changes, debug and byte accesses with directed cases for collisions between set and clear, and for masked flags that must persist.

// File: rtl/irqoff_pkg.sv
package irqoff_pkg;

   typedef enum logic [1:0] {
      SRC_NONE  = 2'd0,
      SRC_BFULL = 2'd1,
      SRC_RLOST = 2'd2,
      SRC_BERR  = 2'd3
   } src_kind_e;

   // class index c reports type code c+1; higher index wins
   localparam int NUM_CLASSES = 3;
   localparam int TYPE_LSB    = 8;
   localparam int OFF_FIELD_W = 4;

endpackage

// File: rtl/irqoff_flags.sv
module irqoff_flags #(
   parameter int CH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CH-1:0] set_i,
   input  logic [CH-1:0] clr_i,
   output logic [CH-1:0] flags_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_o <= '0;
      else        flags_o <= (flags_o & ~clr_i) | set_i;
   end

   // a pulsed set always lands, clear or not
   assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));

   // a stored bit only drops where a clear was requested
   assert_fall_needs_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((flags_o | $past(clr_i)) & $past(flags_o)) == $past(flags_o)));

endmodule

// File: rtl/irqoff_find.sv
module irqoff_find #(
   parameter int CH    = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CH-1:0]    vec_i,
   output logic             hit_o,
   output logic [IDX_W-1:0] idx_o
);

   always_comb begin
      hit_o = 1'b0;
      idx_o = '0;
      for (int i = CH - 1; i >= 0; i--) begin
         if (vec_i[i]) begin
            hit_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end

   assert_lowest_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> (vec_i[idx_o] && ((vec_i & ((CH'(1) << idx_o) - CH'(1))) == '0)));

endmodule

// File: rtl/irq_offset_reg.sv
module irq_offset_reg
   import irqoff_pkg::*;
#(
   parameter int NUM_PAIRS = 8,
   parameter int DATA_W    = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [2*NUM_PAIRS-1:0] set_bfull,
   input  logic [2*NUM_PAIRS-1:0] set_rlost,
   input  logic [2*NUM_PAIRS-1:0] set_berr,
   input  logic [2*NUM_PAIRS-1:0] line_map,
   input  logic                   debug_mode,
   input  logic                   rd_en,
   input  logic [DATA_W/8-1:0]    rd_be,
   output logic [DATA_W-1:0]      rd_data,
   output logic                   irq_line
);

   localparam int CH    = 2 * NUM_PAIRS;
   localparam int IDX_W = (CH > 1) ? $clog2(CH) : 1;
   localparam int BE_W  = DATA_W / 8;

   if (NUM_PAIRS < 1 || NUM_PAIRS > 8) begin : g_bad_pairs
      $error("NUM_PAIRS must lie in 1..8 to fit the offset field");
   end
   if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("DATA_W must be a multiple of 8 and at least 16");
   end

   logic [CH-1:0]    set_v    [NUM_CLASSES];
   logic [CH-1:0]    clr_v    [NUM_CLASSES];
   logic [CH-1:0]    flags_v  [NUM_CLASSES];
   logic [CH-1:0]    masked_v [NUM_CLASSES];
   logic             hit_v    [NUM_CLASSES];
   logic [IDX_W-1:0] idx_v    [NUM_CLASSES];

   always_comb begin
      set_v[0] = set_bfull;
      set_v[1] = set_rlost;
      set_v[2] = set_berr;
   end

   for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
      irqoff_flags #(.CH(CH)) u_flags (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_i   (set_v[c]),
         .clr_i   (clr_v[c]),
         .flags_o (flags_v[c])
      );
      assign masked_v[c] = flags_v[c] & line_map;
      irqoff_find #(.CH(CH), .IDX_W(IDX_W)) u_find (
         .clk   (clk),
         .rst_n (rst_n),
         .vec_i (masked_v[c]),
         .hit_o (hit_v[c]),
         .idx_o (idx_v[c])
      );
   end

   src_kind_e        sel_type;
   logic [IDX_W-1:0] sel_off;
   int unsigned      sel_cls;
   logic             clear_req;
   logic             tgt_set;
   logic             unused_be;

   // later classes override earlier ones: bus error ranks highest
   always_comb begin
      sel_type = SRC_NONE;
      sel_off  = '0;
      sel_cls  = 0;
      for (int c = 0; c < NUM_CLASSES; c++) begin
         if (hit_v[c]) begin
            sel_type = src_kind_e'(2'(c + 1));
            sel_off  = idx_v[c];
            sel_cls  = c;
         end
      end
   end

   assign unused_be = ^rd_be[BE_W-1:2];
   assign clear_req = rd_en && rd_be[0] && rd_be[1] && !debug_mode
                      && (sel_type != SRC_NONE);

   always_comb begin
      for (int c = 0; c < NUM_CLASSES; c++) begin
         clr_v[c] = (clear_req && sel_cls == c) ? (CH'(1) << sel_off) : '0;
      end
   end

   assign tgt_set = set_v[sel_cls][sel_off];

   always_comb begin
      rd_data = '0;
      rd_data[TYPE_LSB +: 2] = sel_type;
      rd_data[IDX_W-1:0]     = sel_off;
   end

   assign irq_line = (sel_type != SRC_NONE);

   assert_berr_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (masked_v[2] != '0) |-> (rd_data[TYPE_LSB +: 2] == 2'd3));

   assert_line_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_line == ((masked_v[0] | masked_v[1] | masked_v[2]) != '0));

   assert_clear_moves_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_req && !tgt_set) |=> (rd_data[9:0] != $past(rd_data[9:0])));

   assert_no_clear_in_debug_R7: assert property (@(posedge clk) disable iff (!rst_n)
      debug_mode |-> (clr_v[0] == '0 && clr_v[1] == '0 && clr_v[2] == '0 && rd_data[7:4] == 4'd0));

endmodule

// File: tb/irq_offset_reg_test.sv
module irq_offset_reg_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] set_bfull = '0, set_rlost = '0, set_berr = '0, line_map = '0;
   logic        debug_mode = 1'b0, rd_en = 1'b0;
   logic [3:0]  rd_be = '0;
   logic [31:0] rd_data;
   logic        irq_line;

   int checks = 0;
   int errors = 0;
   logic [15:0] mf [3];   // model flags: 0 bfull, 1 rlost, 2 berr

   always #2 clk = ~clk;

   irq_offset_reg uut (
      .clk(clk), .rst_n(rst_n), .set_bfull(set_bfull), .set_rlost(set_rlost),
      .set_berr(set_berr), .line_map(line_map), .debug_mode(debug_mode),
      .rd_en(rd_en), .rd_be(rd_be), .rd_data(rd_data), .irq_line(irq_line)
   );

   function automatic logic [31:0] expect_word(logic [15:0] f0, logic [15:0] f1,
                                               logic [15:0] f2, logic [15:0] map);
      logic [15:0] v [3];
      logic [31:0] w;
      v[0] = f0 & map; v[1] = f1 & map; v[2] = f2 & map;
      w = '0;
      for (int c = 2; c >= 0; c--) begin
         if (v[c] != 0) begin
            for (int i = 15; i >= 0; i--) if (v[c][i]) w[3:0] = 4'(i);
            w[9:8] = 2'(c + 1);
            return w;
         end
      end
      return w;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // drive at negedge, check the combinational word, then advance one edge
   task automatic step(logic [15:0] sb, logic [15:0] sr, logic [15:0] se,
                       logic [15:0] map, logic dbg, logic rd, logic [3:0] be,
                       string tag);
      logic [31:0] e;
      logic [15:0] clr [3];
      set_bfull = sb; set_rlost = sr; set_berr = se; line_map = map;
      debug_mode = dbg; rd_en = rd; rd_be = be;
      #1;
      e = expect_word(mf[0], mf[1], mf[2], map);
      check(tag, rd_data, e);
      check("R10", {31'd0, irq_line}, {31'd0, e[9:8] != 2'd0});
      for (int c = 0; c < 3; c++) clr[c] = '0;
      if (rd && be[0] && be[1] && !dbg && e[9:8] != 0)
         clr[e[9:8] - 1] = 16'(1) << e[3:0];
      mf[0] = (mf[0] & ~clr[0]) | sb;
      mf[1] = (mf[1] & ~clr[1]) | sr;
      mf[2] = (mf[2] & ~clr[2]) | se;
      @(negedge clk);
   endtask

   initial begin
      #(4 * 200000);
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int c = 0; c < 3; c++) mf[c] = '0;
      repeat (3) @(negedge clk);
      line_map = 16'hFFFF;
      #1;
      check("R1 reset word", rd_data, 32'd0);
      check("R1 reset irq", {31'd0, irq_line}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 single buffer-full on channel 5 (pair 2, sub B)
      step(16'h0020, 0, 0, 16'hFFFF, 0, 0, 4'h0, "R4 set");
      step(0, 0, 0, 16'hFFFF, 0, 0, 4'h0, "R4 offset 5 type 1");
      check("R5 reserved", rd_data & 32'hFFFF_FCF0, 32'd0);
      // R2 masked channel hides the flag
      step(0, 0, 0, 16'hFFDF, 0, 0, 4'h0, "R2 masked");
      // R3 three classes at once
      step(16'h0004, 16'h0200, 16'h1000, 16'hFFFF, 0, 0, 4'h0, "R3 set");
      step(0, 0, 0, 16'hFFFF, 0, 0, 4'h0, "R3 berr wins");
      // R8 byte reads do not clear
      step(0, 0, 0, 16'hFFFF, 0, 1, 4'h1, "R8 byte0 read");
      step(0, 0, 0, 16'hFFFF, 0, 1, 4'h2, "R8 byte1 read");
      step(0, 0, 0, 16'hFFFF, 0, 1, 4'hC, "R8 upper half read");
      step(0, 0, 0, 16'hFFFF, 0, 0, 4'h0, "R8 still berr 12");
      // R7 debug read does not clear
      step(0, 0, 0, 16'hFFFF, 1, 1, 4'hF, "R7 debug read");
      step(0, 0, 0, 16'hFFFF, 0, 0, 4'h0, "R7 still berr 12");
      // R6 word read then half-word read
      step(0, 0, 0, 16'hFFFF, 0, 1, 4'hF, "R6 word read");
      step(0, 0, 0, 16'hFFFF, 0, 1, 4'h3, "R6 next is rlost 9");
      step(0, 0, 0, 16'hFFFF, 0, 0, 4'h0, "R6 next is bfull 2");
      // R9 set and clear on the same flag
      step(16'h0004, 0, 0, 16'hFFFF, 0, 1, 4'hF, "R9 collide");
      step(0, 0, 0, 16'hFFFF, 0, 0, 4'h0, "R9 flag kept");
      // R11 sticky across map changes
      step(0, 0, 0, 16'h0000, 0, 1, 4'hF, "R11 all masked");
      step(0, 0, 0, 16'hFFFF, 0, 0, 4'h0, "R11 flag returns");
      step(0, 0, 0, 16'hFFFF, 0, 1, 4'hF, "R6 clear last");
      step(0, 0, 0, 16'hFFFF, 0, 0, 4'h0, "R6 empty after clear");

      // random mix
      for (int n = 0; n < 4000; n++) begin
         logic [15:0] sb, sr, se, mp;
         sb = 16'($urandom & $urandom & $urandom & $urandom);
         sr = 16'($urandom & $urandom & $urandom & $urandom);
         se = 16'($urandom & $urandom & $urandom & $urandom & $urandom);
         mp = (($urandom % 4) == 0) ? 16'($urandom) : 16'hFFFF;
         step(sb, sr, se, mp, ($urandom % 6) == 0, ($urandom % 2) == 0,
              4'($urandom), "R6 random");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule